// File: doc/BRIEF.md
# Done-Queue Write Coalescing Cache

This block sits between an internal engine that produces completion entries and the bus master that writes them to a done queue in host memory. The block holds the entries in a small on-chip circular cache. It asks for one burst write-out that carries every entry held at that moment. A burst starts for one of two reasons: the number of cached entries reaches a programmable high watermark, or a programmable flush timer expires while entries are still waiting. The timer keeps the latency bounded when the packet rate is low. The watermark keeps bursts long when the rate is high.

The bus side reads the entries of the current burst by their offset from the oldest entry. It reports completion with a one-cycle done pulse, and that pulse frees the burst's entries. The engine may keep pushing entries during a burst as long as the cache has room. When the cache is full, the engine is held off by backpressure. Each completed burst counts as one write event. The host status bit is raised only after a programmed power-of-two number of write events, and a status read clears it.

Top module: `dq_coalesce_cache`

## Requirements
- R1: After reset, `ent_ready_o` is 1, `burst_req_o` is 0 and `stat_o` is 0.
- R2: When no burst is in flight and the number of cached entries is nonzero and at least `hwm_i`, `burst_req_o` rises at the next clock edge. At that point `burst_len_o` equals the number of entries cached before that edge.
- R3: When one entry enters an empty cache and the watermark is not reached, `burst_req_o` rises exactly `flush_time_i + 1` clock edges after the edge that accepted the entry.
- R4: While `burst_req_o` is 1 and `burst_done_i` is 0, `burst_req_o` and `burst_len_o` hold their values. A `burst_done_i` pulse during a burst frees exactly `burst_len_o` of the oldest entries.
- R5: `rd_data_o` shows the cached entry at offset `rd_off_i` from the oldest entry, and entries keep their arrival order.
- R6: Entries are accepted while a burst is in flight as long as fewer than `DEPTH` entries are held. With `DEPTH` entries held, `ent_ready_o` is 0, and a valid entry offered at that time is not stored.
- R7: A `burst_done_i` pulse while no burst is in flight has no effect: no burst starts and no entry is freed.
- R8: With threshold code n on `thresh_i` (3 bits), `stat_o` rises at the 2^n-th completed burst counted since it was last set. Code 0 sets it on every completed burst.
- R9: A pulse on `host_rd_i` clears `stat_o` at the next edge. If a completed burst reaches the threshold in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ent_valid_i | input | 1 | Engine offers an entry |
| ent_data_i | input | ENTRY_W | Entry payload |
| ent_ready_o | output | 1 | Cache has room; entry accepted when valid and ready |
| hwm_i | input | CNT_W | High watermark in entries (1 to DEPTH) |
| flush_time_i | input | TIMER_W | Flush timeout in clock cycles |
| thresh_i | input | 3 | Write-event threshold code, 2^n events |
| burst_req_o | output | 1 | Burst write-out requested and in flight |
| burst_len_o | output | CNT_W | Entries in the current burst |
| rd_off_i | input | PTR_W | Offset from the oldest entry for reading |
| rd_data_o | output | ENTRY_W | Entry at the selected offset |
| burst_done_i | input | 1 | Bus side finished the current burst |
| host_rd_i | input | 1 | Host read of the status register |
| stat_o | output | 1 | Done-queue write status bit |

## Verification
The main function is tried with three input patterns. The first is a run of back-to-back entries that exactly reaches the watermark, which separates a watermark trigger from a timed one by both burst length and timing. The second is a single entry with a high watermark, which isolates the flush timer so the latency from acceptance to request can be counted edge by edge. The third fills the cache during a burst, which shows backpressure, shows that a refused entry is dropped, and shows that the leftover entries start a second burst in arrival order. Stray done pulses and threshold codes 0 and 2 separate per-write status from coalesced status, and a host read that lands on a setting event shows which one has priority.

// File: rtl/dqc_pkg.sv
package dqc_pkg;
  localparam int unsigned THR_W = 3;
  // counter must reach 2^(2^THR_W - 1)
  localparam int unsigned EVT_W = 1 << THR_W;
endpackage

// File: rtl/dqc_store.sv
module dqc_store #(
  parameter int unsigned ENTRY_W = 32,
  parameter int unsigned DEPTH   = 16,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [ENTRY_W-1:0] push_data_i,
  input  logic               rel_i,
  input  logic [CNT_W-1:0]   rel_len_i,
  input  logic [PTR_W-1:0]   rd_off_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]   count_o
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]   head_q, tail_q;
  logic [CNT_W-1:0]   count_q;
  logic [PTR_W-1:0]   rd_idx;

  assign rd_idx    = head_q + rd_off_i;
  assign rd_data_o = mem_q[rd_idx];
  assign count_o   = count_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[tail_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (rel_i)  head_q <= head_q + rel_len_i[PTR_W-1:0];
      count_q <= count_q + CNT_W'(push_i) - (rel_i ? rel_len_i : '0);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> count_q < CNT_W'(DEPTH)); // R6
  AST_REL_WITHIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |-> (rel_len_i <= count_q && rel_len_i != '0)); // R4
endmodule

// File: rtl/dqc_trigger.sv
module dqc_trigger #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TIMER_W = 16,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [CNT_W-1:0]   hwm_i,
  input  logic [TIMER_W-1:0] flush_time_i,
  input  logic               done_i,
  output logic               busy_o,
  output logic [CNT_W-1:0]   len_o,
  output logic               finish_o
);
  logic               busy_q;
  logic [CNT_W-1:0]   len_q;
  logic [TIMER_W-1:0] timer_q;
  logic               wm_hit, to_hit, fire;

  assign wm_hit   = count_i >= hwm_i;
  assign to_hit   = timer_q >= flush_time_i;
  assign fire     = !busy_q && (count_i != '0) && (wm_hit || to_hit);
  assign finish_o = busy_q && done_i;
  assign busy_o   = busy_q;
  assign len_o    = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      len_q   <= '0;
      timer_q <= '0;
    end else begin
      if (fire) begin
        busy_q <= 1'b1;
        len_q  <= count_i;
      end else if (finish_o) begin
        busy_q <= 1'b0;
      end
      // timer restarts at each burst start and idles on an empty cache
      if (count_i == '0 || fire) timer_q <= '0;
      else if (timer_q != '1)    timer_q <= timer_q + 1'b1;
    end
  end

  AST_WM_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && count_i != '0 && count_i >= hwm_i) |=> busy_q); // R2
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> (busy_q && $stable(len_q))); // R4
  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (len_q != '0 && len_q <= CNT_W'(DEPTH))); // R4
  AST_IDLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && count_i == '0) |=> !busy_q); // R7
endmodule

// File: rtl/dqc_status.sv
module dqc_status
  import dqc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic             host_rd_i,
  output logic             stat_o
);
  logic [EVT_W-1:0] evt_cnt_q;
  logic [EVT_W:0]   target, next_cnt;
  logic             hit;
  logic             stat_q;

  assign target   = (EVT_W+1)'(1) << thresh_i;
  assign next_cnt = {1'b0, evt_cnt_q} + 1'b1;
  assign hit      = evt_i && (next_cnt >= target);
  assign stat_o   = stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_cnt_q <= '0;
      stat_q    <= 1'b0;
    end else begin
      if (hit)        evt_cnt_q <= '0;
      else if (evt_i) evt_cnt_q <= next_cnt[EVT_W-1:0];
      if (hit)            stat_q <= 1'b1;
      else if (host_rd_i) stat_q <= 1'b0;
    end
  end

  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !evt_i) |=> !stat_q); // R9
  AST_NO_SET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !stat_q) |=> !stat_q); // R8
  AST_CODE0_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && thresh_i == '0) |=> stat_q); // R8
endmodule

// File: rtl/dq_coalesce_cache.sv
module dq_coalesce_cache
  import dqc_pkg::*;
#(
  parameter int unsigned ENTRY_W = 32,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TIMER_W = 16,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ent_valid_i,
  input  logic [ENTRY_W-1:0] ent_data_i,
  output logic               ent_ready_o,
  input  logic [CNT_W-1:0]   hwm_i,
  input  logic [TIMER_W-1:0] flush_time_i,
  input  logic [THR_W-1:0]   thresh_i,
  output logic               burst_req_o,
  output logic [CNT_W-1:0]   burst_len_o,
  input  logic [PTR_W-1:0]   rd_off_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  input  logic               burst_done_i,
  input  logic               host_rd_i,
  output logic               stat_o
);
  logic [CNT_W-1:0] count;
  logic             push, finish;

  assign ent_ready_o = count < CNT_W'(DEPTH);
  assign push        = ent_valid_i && ent_ready_o;

  dqc_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (ent_data_i),
    .rel_i       (finish),
    .rel_len_i   (burst_len_o),
    .rd_off_i    (rd_off_i),
    .rd_data_o   (rd_data_o),
    .count_o     (count)
  );

  dqc_trigger #(.DEPTH(DEPTH), .TIMER_W(TIMER_W)) i_trigger (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .count_i      (count),
    .hwm_i        (hwm_i),
    .flush_time_i (flush_time_i),
    .done_i       (burst_done_i),
    .busy_o       (burst_req_o),
    .len_o        (burst_len_o),
    .finish_o     (finish)
  );

  dqc_status i_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (finish),
    .thresh_i  (thresh_i),
    .host_rd_i (host_rd_i),
    .stat_o    (stat_o)
  );

  AST_FULL_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_valid_i && !ent_ready_o && !finish) |=> !ent_ready_o); // R6
  AST_STRAY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_done_i && !burst_req_o) |=> $stable(ent_ready_o) || push); // R7
endmodule

// File: tb/test_dq_coalesce_cache.sv
module test_dq_coalesce_cache;
  localparam int unsigned EW = 32, DEPTH = 16, TW = 16;
  localparam int unsigned PW = $clog2(DEPTH), CW = $clog2(DEPTH + 1);

  logic          clk = 0, rst_n = 0;
  logic          valid = 0, ready;
  logic [EW-1:0] data = '0, rd_data;
  logic [CW-1:0] hwm = CW'(4), blen;
  logic [TW-1:0] flush = TW'(1000);
  logic [2:0]    thresh = '0;
  logic          req, done = 0, hrd = 0, stat;
  logic [PW-1:0] off = '0;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  dq_coalesce_cache #(.ENTRY_W(EW), .DEPTH(DEPTH), .TIMER_W(TW)) i_dq_coalesce_cache (
    .clk_i(clk), .rst_ni(rst_n), .ent_valid_i(valid), .ent_data_i(data),
    .ent_ready_o(ready), .hwm_i(hwm), .flush_time_i(flush), .thresh_i(thresh),
    .burst_req_o(req), .burst_len_o(blen), .rd_off_i(off), .rd_data_o(rd_data),
    .burst_done_i(done), .host_rd_i(hrd), .stat_o(stat));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [EW-1:0] d);
    @(negedge clk); valid = 1; data = d;
    while (!ready) @(negedge clk);
    @(posedge clk); #1 valid = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1;
    @(posedge clk); #1 done = 0;
  endtask

  task automatic host_read();
    @(negedge clk); hrd = 1;
    @(posedge clk); #1 hrd = 0;
  endtask

  task automatic wait_req();
    while (!req) begin @(posedge clk); #1; end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ready", ready, 1);
    chk("R1 req", req, 0);
    chk("R1 stat", stat, 0);
  endtask

  task automatic t_watermark();
    hwm = CW'(4); flush = TW'(1000); thresh = 3'd0;
    for (int i = 0; i < 4; i++) push(32'hA0 + i);
    chk("R2 no req before edge", req, 0);
    @(posedge clk); #1;
    chk("R2 req", req, 1);
    chk("R2 len", blen, 4);
    for (int i = 0; i < 4; i++) begin
      off = PW'(i); #1;
      chk("R5 order", rd_data, 32'hA0 + i);
    end
    off = '0;
    pulse_done();
    chk("R4 req drops", req, 0);
    chk("R8 code0 sets", stat, 1);
    host_read();
    chk("R9 clear", stat, 0);
  endtask

  task automatic t_flush();
    int k;
    hwm = CW'(16); flush = TW'(5);
    push(32'hF1);
    k = 0;
    while (!req && k < 100) begin @(posedge clk); #1; k++; end
    chk("R3 latency", k, 6);
    chk("R3 len", blen, 1);
    chk("R3 data", rd_data, 32'hF1);
    pulse_done();
  endtask

  task automatic t_full();
    hwm = CW'(4); flush = TW'(1000);
    for (int i = 0; i < 4; i++) push(32'hB0 + i);
    @(posedge clk); #1;
    chk("R2 burst", req, 1);
    for (int i = 4; i < 16; i++) push(32'hB0 + i);
    #1;
    chk("R6 full holdoff", ready, 0);
    @(negedge clk); valid = 1; data = 32'hDEAD;
    repeat (2) @(posedge clk);
    #1 valid = 0;
    chk("R4 len stable", blen, 4);
    chk("R4 req stable", req, 1);
    pulse_done();
    chk("R4 freed space", ready, 1);
    @(posedge clk); #1;
    chk("R6 second burst", req, 1);
    chk("R6 leftover len", blen, 12);
    off = '0; #1;
    chk("R5 head after release", rd_data, 32'hB4);
    off = PW'(11); #1;
    chk("R6 refused entry not stored", rd_data, 32'hBF);
    off = '0;
    pulse_done();
  endtask

  task automatic t_stray();
    hwm = CW'(1); flush = TW'(1000);
    pulse_done();
    repeat (2) @(posedge clk); #1;
    chk("R7 no burst", req, 0);
    push(32'hC7);
    wait_req();
    chk("R7 count intact", blen, 1);
    chk("R7 data", rd_data, 32'hC7);
    pulse_done();
  endtask

  task automatic t_thresh();
    host_read();
    thresh = 3'd2; hwm = CW'(1);
    for (int i = 0; i < 4; i++) begin
      push(32'hD0 + i);
      wait_req();
      pulse_done();
      if (i < 3) chk("R8 below threshold", stat, 0);
      else       chk("R8 fourth event sets", stat, 1);
    end
    host_read();
    chk("R9 clear after read", stat, 0);
    thresh = 3'd0;
    push(32'hE0);
    wait_req();
    @(negedge clk); done = 1; hrd = 1;
    @(posedge clk); #1 done = 0; hrd = 0;
    chk("R9 set wins over read", stat, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rst_n = 1;
    t_watermark();
    t_flush();
    t_full();
    t_stray();
    t_thresh();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule